// File: doc/BRIEF.md
# Fixed-Point ALU with Status Flags

This block is the 32-bit fixed-point arithmetic and logic unit of a DSP datapath. Each cycle that `op_valid` is high it takes two operands from 40-bit register slots (the 32-bit value sits in bits 39..8) and a 5-bit opcode. One clock edge later it writes a 32-bit result back into a 40-bit slot with a zero low byte. A second result slot is written only by the dual add/subtract operation.

Alongside the results the block keeps an arithmetic status word and a sticky status word. The status word holds zero, overflow, negative, carry and input-sign flags, plus an eight-deep history of compare outcomes. The carry flag feeds the carry-in of the next operation. A saturation input picks, per operation, whether signed overflow clamps or wraps. The sticky overflow bit collects overflows until a clear pulse arrives.

Top module: `fxalu_top`

## Requirements
- R1: Operands are taken from slot bits 39..8, and slot bits 7..0 have no effect. Result slots carry the result in bits 39..8 with bits 7..0 zero. Results and status appear one clock edge after `op_valid`, and all outputs hold while `op_valid` is low.
- R2: Opcode encodings are ADD=0, SUB=1, ADDC=2, SUBB=3, XPC=4, XMC=5, INC=6, DEC=7, NEG=8, AVG=9, ABS=10, PASS=11, MIN=12, MAX=13, CLIP=14, CMP=15, DUAL=16, AND=17, OR=18, XOR=19, NOT=20. ADD, SUB, INC, DEC and NEG produce x+y, x-y, x+1, x-1 and 0-x modulo 2^32 when saturation is off.
- R3: With CI equal to the carry flag held in the status word, ADDC gives x+y+CI, SUBB gives x-y+CI-1, XPC gives x+CI and XMC gives x+CI-1.
- R4: AVG returns bits 32..1 of the 33-bit signed sum x+y, so it never overflows and the sign is kept.
- R5: ABS returns |x| and sets status bit 4 to the sign of x. ABS of 0x80000000 overflows.
- R6: PASS returns x. MIN and MAX return the signed minimum and maximum of x and y.
- R7: CLIP limits x to the range -|y|..+|y|, where |0x80000000| is taken as 0x7FFFFFFF.
- R8: CMP leaves both result slots unchanged. It sets bit 0 when x equals y and bit 2 when x is less than y (signed). It shifts status bits 31..24 right by one, with bit 31 set to 1 when x is greater than y (signed).
- R9: DUAL writes x+y to the main slot and x-y to the second slot in the same cycle. Its zero, negative and overflow flags are the OR over both results, and its carry comes from the sum.
- R10: AND, OR, XOR and NOT are bitwise, with NOT acting on x. They clear the overflow and carry flags.
- R11: When `sat_en` is high, a signed overflow replaces the result with 0x7FFFFFFF if the true result is positive and with 0x80000000 otherwise. When it is low, the result wraps.
- R12: Status bit 0 is zero-result, bit 1 is overflow, bit 2 is result-negative (bit 31 of the final result), bit 3 is the unsigned carry out of the adder (ADD, SUB, carry forms, INC, DEC, NEG, AVG, DUAL; 0 otherwise), bit 4 is the ABS input sign (0 otherwise), and bit 10 is always 0.
- R13: Sticky bit 2 is set by every operation that sets the overflow flag. It is cleared only by `sticky_clr`. When a clear and an overflowing operation meet in one cycle, the bit ends up set.
- R14: Synchronous active-high reset clears both result slots, the status word, the sticky word and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Execute the presented operation this cycle |
| op_code | input | 5 | Operation select |
| sat_en | input | 1 | Saturate on signed overflow |
| rx_slot | input | 40 | First operand slot |
| ry_slot | input | 40 | Second operand slot |
| sticky_clr | input | 1 | Clear the sticky word |
| rn_slot | output | 40 | Main result slot |
| rm_slot | output | 40 | Second result slot (DUAL only) |
| res_valid | output | 1 | Result written on the last edge |
| stat_word | output | 32 | Arithmetic status and compare history |
| sticky_word | output | 32 | Sticky status |

## Verification
The sticky overflow bit has two sources that can land on one edge: the explicit clear and an operation whose overflow flag sets it. The bench raises `sticky_clr` in the same cycle as an ADD of 0x7FFFFFFF and 1. It expects the bit to read 1 afterwards, after first showing that a lone clear drops it to 0 and that a non-overflowing operation leaves it at 0. A second overlap is the carry flag. It is both read as CI and rewritten by the same operation, and this is judged by chains of carry forms whose expected values depend on the flag left by the step before.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_ADDC = 5'd2,  OP_SUBB = 5'd3,
    OP_XPC  = 5'd4,  OP_XMC  = 5'd5,  OP_INC  = 5'd6,  OP_DEC  = 5'd7,
    OP_NEG  = 5'd8,  OP_AVG  = 5'd9,  OP_ABS  = 5'd10, OP_PASS = 5'd11,
    OP_MIN  = 5'd12, OP_MAX  = 5'd13, OP_CLIP = 5'd14, OP_CMP  = 5'd15,
    OP_DUAL = 5'd16, OP_AND  = 5'd17, OP_OR   = 5'd18, OP_XOR  = 5'd19,
    OP_NOT  = 5'd20
  } fx_op_e;

  typedef struct packed {
    logic sgn_in;
    logic carry;
    logic neg;
    logic ovf;
    logic zero;
  } fx_flags_t;

  localparam int FLAG_W  = 5;
  localparam int FP_BIT  = 10;
  localparam int HIST_LO = 24;
  localparam int HIST_W  = 8;
  localparam int STAT_W  = 32;
  localparam int STKY_OV = 2;
endpackage

// File: rtl/fxalu_adder.sv
module fxalu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] full;
  assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/fxalu_core.sv
module fxalu_core
  import fxalu_pkg::*;
#(
  parameter int W = 32
) (
  input  fx_op_e    op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic      ci,
  input  logic      sat,
  output logic [W-1:0] res,
  output logic [W-1:0] res2,
  output fx_flags_t flags,
  output logic      is_cmp,
  output logic      is_dual,
  output logic      gt
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};
  localparam logic [W-1:0] ZERO = {W{1'b0}};

  logic [W-1:0] a_op, b_op, s_main, s_sub;
  logic         c_in, c_main, v_main, c_sub, v_sub;
  logic [W:0]   avg_sum;
  logic [W-1:0] sat_main, sat_sub, lim, nlim;
  logic         lt, eq;

  always_comb begin
    a_op = x;
    b_op = ZERO;
    c_in = 1'b0;
    case (op)
      OP_ADD, OP_AVG, OP_DUAL: begin b_op = y; end
      OP_SUB:  begin b_op = ~y; c_in = 1'b1; end
      OP_ADDC: begin b_op = y;  c_in = ci;   end
      OP_SUBB: begin b_op = ~y; c_in = ci;   end
      OP_XPC:  begin c_in = ci; end
      OP_XMC:  begin b_op = ONES; c_in = ci; end
      OP_INC:  begin c_in = 1'b1; end
      OP_DEC:  begin b_op = ONES; end
      OP_NEG:  begin a_op = ZERO; b_op = ~x; c_in = 1'b1; end
      OP_ABS:  begin
        if (x[W-1]) begin a_op = ZERO; b_op = ~x; c_in = 1'b1; end
      end
      default: ;
    endcase
  end

  fxalu_adder #(.W(W)) u_main (
    .a(a_op), .b(b_op), .cin(c_in), .sum(s_main), .cout(c_main), .ovf(v_main)
  );

  fxalu_adder #(.W(W)) u_dsub (
    .a(x), .b(~y), .cin(1'b1), .sum(s_sub), .cout(c_sub), .ovf(v_sub)
  );

  assign avg_sum  = {x[W-1], x} + {y[W-1], y};
  assign sat_main = (v_main && sat) ? (s_main[W-1] ? MAXP : MINN) : s_main;
  assign sat_sub  = (v_sub && sat) ? (s_sub[W-1] ? MAXP : MINN) : s_sub;
  assign lim      = y[W-1] ? ((y == MINN) ? MAXP : (ZERO - y)) : y;
  assign nlim     = ZERO - lim;
  assign lt       = $signed(x) < $signed(y);
  assign eq       = (x == y);
  assign gt       = !lt && !eq;
  assign is_cmp   = (op == OP_CMP);
  assign is_dual  = (op == OP_DUAL);

  logic unused_subc;
  assign unused_subc = c_sub;

  always_comb begin
    res   = x;
    res2  = sat_sub;
    flags = '0;
    case (op)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBB, OP_XPC, OP_XMC,
      OP_INC, OP_DEC, OP_NEG: begin
        res         = sat_main;
        flags.ovf   = v_main;
        flags.carry = c_main;
      end
      OP_AVG: begin
        res         = avg_sum[W:1];
        flags.carry = c_main;
      end
      OP_ABS: begin
        res          = sat_main;
        flags.ovf    = v_main;
        flags.sgn_in = x[W-1];
      end
      OP_PASS: res = x;
      OP_MIN:  res = lt ? x : y;
      OP_MAX:  res = lt ? y : x;
      OP_CLIP: begin
        if ($signed(x) > $signed(lim))       res = lim;
        else if ($signed(x) < $signed(nlim)) res = nlim;
        else                                 res = x;
      end
      OP_DUAL: begin
        res         = sat_main;
        flags.ovf   = v_main | v_sub;
        flags.carry = c_main;
      end
      OP_AND:  res = x & y;
      OP_OR:   res = x | y;
      OP_XOR:  res = x ^ y;
      OP_NOT:  res = ~x;
      default: res = x;
    endcase
    if (op == OP_CMP) begin
      flags.zero = eq;
      flags.neg  = lt;
    end else if (op == OP_DUAL) begin
      flags.zero = (res == ZERO) || (res2 == ZERO);
      flags.neg  = res[W-1] | res2[W-1];
    end else begin
      flags.zero = (res == ZERO);
      flags.neg  = res[W-1];
    end
  end
endmodule

// File: rtl/fxalu_status.sv
module fxalu_status
  import fxalu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  fx_flags_t        flags_in,
  input  logic             is_cmp,
  input  logic             gt,
  input  logic             sticky_clr,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] sticky_o,
  output logic             ci_o
);
  logic [STAT_W-1:0] stat_q, sticky_q;
  logic [HIST_W-1:0] hist_nxt;

  generate
    for (genvar i = 0; i < HIST_W - 1; i++) begin : g_hist
      assign hist_nxt[i] = stat_q[HIST_LO + i + 1];
    end
  endgenerate
  assign hist_nxt[HIST_W-1] = gt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q   <= '0;
      sticky_q <= '0;
    end else begin
      if (op_valid) begin
        stat_q[FLAG_W-1:0] <= flags_in;
        stat_q[FP_BIT]     <= 1'b0;
        if (is_cmp) stat_q[HIST_LO +: HIST_W] <= hist_nxt;
      end
      if (sticky_clr) sticky_q <= '0;
      if (op_valid && flags_in.ovf) sticky_q[STKY_OV] <= 1'b1;
    end
  end

  assign stat_o   = stat_q;
  assign sticky_o = sticky_q;
  assign ci_o     = stat_q[3];

  // R13: an overflowing operation always leaves the sticky bit set
  a_r13_sticky_set: assert property (@(posedge clk) disable iff (rst)
    (op_valid && flags_in.ovf) |=> sticky_q[STKY_OV]);
  // R13: only an explicit clear drops the sticky bit
  a_r13_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (sticky_q[STKY_OV] && !sticky_clr) |=> sticky_q[STKY_OV]);
  // R8: compare shifts the history by one place
  a_r8_hist_shift: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_cmp) |=> (stat_q[HIST_LO +: HIST_W-1] == $past(stat_q[HIST_LO+1 +: HIST_W-1])));
  // R1: status holds while no operation is issued
  a_r1_stat_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(stat_q));
  // R12: floating-point marker never set
  a_r12_fp_clear: assert property (@(posedge clk) disable iff (rst)
    !stat_q[FP_BIT]);
endmodule

// File: rtl/fxalu_top.sv
module fxalu_top
  import fxalu_pkg::*;
#(
  parameter int W   = 32,
  parameter int PAD = 8,
  localparam int SW = W + PAD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic          sat_en,
  input  logic [SW-1:0] rx_slot,
  input  logic [SW-1:0] ry_slot,
  input  logic          sticky_clr,
  output logic [SW-1:0] rn_slot,
  output logic [SW-1:0] rm_slot,
  output logic          res_valid,
  output logic [31:0]   stat_word,
  output logic [31:0]   sticky_word
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};

  fx_op_e       op;
  logic [W-1:0] x, y, res, res2;
  fx_flags_t    flags;
  logic         is_cmp, is_dual, gt, ci;
  logic [W-1:0] rn_q, rm_q;
  logic         valid_q;

  logic [2*PAD-1:0] unused_low;
  assign unused_low = {rx_slot[PAD-1:0], ry_slot[PAD-1:0]};

  assign op = fx_op_e'(op_code);
  assign x  = rx_slot[SW-1:PAD];
  assign y  = ry_slot[SW-1:PAD];

  fxalu_core #(.W(W)) u_core (
    .op(op), .x(x), .y(y), .ci(ci), .sat(sat_en),
    .res(res), .res2(res2), .flags(flags),
    .is_cmp(is_cmp), .is_dual(is_dual), .gt(gt)
  );

  fxalu_status u_stat (
    .clk(clk), .rst(rst), .op_valid(op_valid), .flags_in(flags),
    .is_cmp(is_cmp), .gt(gt), .sticky_clr(sticky_clr),
    .stat_o(stat_word), .sticky_o(sticky_word), .ci_o(ci)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rn_q    <= '0;
      rm_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= op_valid;
      if (op_valid && !is_cmp) rn_q <= res;
      if (op_valid && is_dual) rm_q <= res2;
    end
  end

  assign rn_slot   = {rn_q, {PAD{1'b0}}};
  assign rm_slot   = {rm_q, {PAD{1'b0}}};
  assign res_valid = valid_q;

  // R11: a saturated overflow lands on one of the two rails
  a_r11_sat_rail: assert property (@(posedge clk) disable iff (rst)
    (op_valid && sat_en && flags.ovf && !is_cmp && !is_dual)
      |=> (rn_q == MAXP || rn_q == MINN));
  // R8: compare never writes the main slot
  a_r8_cmp_keep: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_cmp) |=> $stable(rn_q));
  // R1: result slots hold while idle
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(rn_q) && $stable(rm_q)));
endmodule

// File: tb/sim_fxalu_top.sv
module sim_fxalu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic        sat_en = 1'b0;
  logic [39:0] rx_slot = '0, ry_slot = '0;
  logic        sticky_clr = 1'b0;
  logic [39:0] rn_slot, rm_slot;
  logic        res_valid;
  logic [31:0] stat_word, sticky_word;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fxalu_top u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .sat_en(sat_en), .rx_slot(rx_slot), .ry_slot(ry_slot),
    .sticky_clr(sticky_clr), .rn_slot(rn_slot), .rm_slot(rm_slot),
    .res_valid(res_valid), .stat_word(stat_word), .sticky_word(sticky_word)
  );

  // {op, sat, x, y, expected result, expected flags AS AC AN AV AZ}
  localparam int NV = 26;
  localparam logic [106:0] VEC [NV] = '{
    {5'd0,  1'b0, 32'h00000005, 32'h00000003, 32'h00000008, 5'h00}, // R2
    {5'd0,  1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 5'h06}, // R2 R11
    {5'd0,  1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 5'h02}, // R11
    {5'd0,  1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 5'h09}, // R12
    {5'd1,  1'b0, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 5'h04}, // R2
    {5'd1,  1'b1, 32'h80000000, 32'h00000001, 32'h80000000, 5'h0E}, // R11
    {5'd9,  1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'h00}, // R4
    {5'd9,  1'b0, 32'hFFFFFFFF, 32'hFFFFFFFC, 32'hFFFFFFFD, 5'h0C}, // R4
    {5'd8,  1'b0, 32'h80000000, 32'h00000000, 32'h80000000, 5'h06}, // R2
    {5'd8,  1'b1, 32'h00000005, 32'h00000000, 32'hFFFFFFFB, 5'h04}, // R2
    {5'd6,  1'b0, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 5'h09}, // R2
    {5'd7,  1'b0, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 5'h04}, // R2
    {5'd10, 1'b0, 32'h80000000, 32'h00000000, 32'h80000000, 5'h16}, // R5
    {5'd10, 1'b1, 32'h80000000, 32'h00000000, 32'h7FFFFFFF, 5'h12}, // R5 R11
    {5'd10, 1'b0, 32'hFFFFFFF6, 32'h00000000, 32'h0000000A, 5'h10}, // R5
    {5'd11, 1'b0, 32'h00000000, 32'h12345678, 32'h00000000, 5'h01}, // R6
    {5'd12, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 5'h04}, // R6
    {5'd13, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 5'h00}, // R6
    {5'd14, 1'b0, 32'h00000064, 32'hFFFFFFCE, 32'h00000032, 5'h00}, // R7
    {5'd14, 1'b0, 32'hFFFFFF9C, 32'h00000032, 32'hFFFFFFCE, 5'h04}, // R7
    {5'd14, 1'b0, 32'h00000014, 32'h00000032, 32'h00000014, 5'h00}, // R7
    {5'd17, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 5'h04}, // R10
    {5'd18, 1'b0, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'hFFFFFFFF, 5'h04}, // R10
    {5'd19, 1'b0, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000, 5'h01}, // R10
    {5'd20, 1'b0, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 5'h01}, // R10
    {5'd14, 1'b0, 32'h80000000, 32'h80000000, 32'h80000001, 5'h04}  // R7
  };

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] op, input logic sat,
                        input logic [31:0] x, input logic [31:0] y,
                        input logic [7:0] low, input logic clr);
    @(negedge clk);
    op_code    = op;
    sat_en     = sat;
    rx_slot    = {x, low};
    ry_slot    = {y, ~low};
    sticky_clr = clr;
    op_valid   = 1'b1;
    @(negedge clk);
    op_valid   = 1'b0;
    sticky_clr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [39:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R14 reset state
    check("R14 rn", rn_slot, 40'h0);
    check("R14 rm", rm_slot, 40'h0);
    check("R14 stat", {8'h0, stat_word}, 40'h0);
    check("R14 sticky", {8'h0, sticky_word}, 40'h0);
    check("R14 valid", {39'h0, res_valid}, 40'h0);

    for (int i = 0; i < NV; i++) begin
      logic [106:0] v;
      v = VEC[i];
      run_op(v[106:102], v[101], v[100:69], v[68:37], 8'h00, 1'b0);
      check($sformatf("R2 vector %0d result", i), rn_slot, {v[36:5], 8'h00});
      check($sformatf("R12 vector %0d flags", i), {35'h0, stat_word[4:0]}, {35'h0, v[4:0]});
      check($sformatf("R12 vector %0d fp bit", i), {39'h0, stat_word[10]}, 40'h0);
      check($sformatf("R1 vector %0d valid", i), {39'h0, res_valid}, 40'h1);
    end

    // R3 carry forms
    run_op(5'd0, 1'b0, 32'hFFFFFFFF, 32'h1, 8'h00, 1'b0);   // AC=1
    run_op(5'd2, 1'b0, 32'h5, 32'h3, 8'h00, 1'b0);
    check("R3 addc ci=1", rn_slot, {32'h9, 8'h00});
    run_op(5'd2, 1'b0, 32'h5, 32'h3, 8'h00, 1'b0);
    check("R3 addc ci=0", rn_slot, {32'h8, 8'h00});
    run_op(5'd3, 1'b0, 32'h5, 32'h3, 8'h00, 1'b0);
    check("R3 subb ci=0", rn_slot, {32'h1, 8'h00});
    check("R3 subb carry", {39'h0, stat_word[3]}, 40'h1);
    run_op(5'd4, 1'b0, 32'h10, 32'h0, 8'h00, 1'b0);
    check("R3 xpc ci=1", rn_slot, {32'h11, 8'h00});
    run_op(5'd5, 1'b0, 32'h10, 32'h0, 8'h00, 1'b0);
    check("R3 xmc ci=0", rn_slot, {32'hF, 8'h00});
    run_op(5'd5, 1'b0, 32'h10, 32'h0, 8'h00, 1'b0);
    check("R3 xmc ci=1", rn_slot, {32'h10, 8'h00});

    // R9 dual add/subtract
    run_op(5'd16, 1'b0, 32'h10, 32'h3, 8'h00, 1'b0);
    check("R9 dual sum", rn_slot, {32'h13, 8'h00});
    check("R9 dual diff", rm_slot, {32'hD, 8'h00});
    check("R9 dual flags", {36'h0, stat_word[3:0]}, 40'h0);
    run_op(5'd16, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 8'h00, 1'b0);
    check("R9 dual sat sum", rn_slot, {32'h7FFFFFFE, 8'h00});
    check("R9 R11 dual sat diff", rm_slot, {32'h7FFFFFFF, 8'h00});
    check("R9 dual ovf flags", {36'h0, stat_word[3:0]}, 40'hA);
    run_op(5'd0, 1'b0, 32'h1, 32'h1, 8'h00, 1'b0);
    check("R9 rm kept by add", rm_slot, {32'h7FFFFFFF, 8'h00});

    // R1 low operand bits ignored
    run_op(5'd0, 1'b0, 32'h20, 32'h2, 8'hFF, 1'b0);
    check("R1 low bits ignored", rn_slot, {32'h22, 8'h00});

    // R8 compare history and flags
    held = rn_slot;
    run_op(5'd15, 1'b0, 32'h5, 32'h3, 8'h00, 1'b0);
    check("R8 hist gt", {32'h0, stat_word[31:24]}, 40'h80);
    check("R8 rn kept", rn_slot, held);
    run_op(5'd15, 1'b0, 32'h3, 32'h3, 8'h00, 1'b0);
    check("R8 hist eq", {32'h0, stat_word[31:24]}, 40'h40);
    check("R8 eq flags", {37'h0, stat_word[2:0]}, 40'h1);
    run_op(5'd15, 1'b0, 32'hFFFFFFFF, 32'h1, 8'h00, 1'b0);
    check("R8 hist lt", {32'h0, stat_word[31:24]}, 40'h20);
    check("R8 lt flags", {37'h0, stat_word[2:0]}, 40'h4);
    run_op(5'd15, 1'b0, 32'h2, 32'h1, 8'h00, 1'b0);
    check("R8 hist shift", {32'h0, stat_word[31:24]}, 40'h90);
    run_op(5'd0, 1'b0, 32'h1, 32'h2, 8'h00, 1'b0);
    check("R8 hist kept by add", {32'h0, stat_word[31:24]}, 40'h90);

    // R13 sticky overflow
    check("R13 sticky set earlier", {39'h0, sticky_word[2]}, 40'h1);
    @(negedge clk);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
    check("R13 sticky cleared", {8'h0, sticky_word}, 40'h0);
    run_op(5'd0, 1'b0, 32'h1, 32'h1, 8'h00, 1'b0);
    check("R13 no ovf no set", {39'h0, sticky_word[2]}, 40'h0);
    run_op(5'd0, 1'b0, 32'h7FFFFFFF, 32'h1, 8'h00, 1'b1);
    check("R13 clr with ovf", {39'h0, sticky_word[2]}, 40'h1);
    run_op(5'd17, 1'b0, 32'h1, 32'h1, 8'h00, 1'b0);
    check("R13 sticky holds", {39'h0, sticky_word[2]}, 40'h1);
    check("R10 and clears AV", {39'h0, stat_word[1]}, 40'h0);

    // R1 idle hold
    held = rn_slot;
    @(negedge clk);
    op_code = 5'd0;
    rx_slot = 40'hFFFFFFFFFF;
    ry_slot = 40'h1234567800;
    repeat (3) @(negedge clk);
    check("R1 idle rn", rn_slot, held);
    check("R1 idle stat", {39'h0, stat_word[0]}, 40'h0);
    check("R1 idle valid", {39'h0, res_valid}, 40'h0);

    // R14 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R14 rn after reset", rn_slot, 40'h0);
    check("R14 stat after reset", {8'h0, stat_word}, 40'h0);
    check("R14 sticky after reset", {8'h0, sticky_word}, 40'h0);

    finish_run();
  end
endmodule